// File: doc/BRIEF.md
# Programmable BERT Pattern Generator

This block produces a bit-error-rate test pattern one bit at a time. The pattern is meant to fill the payload of one chosen outgoing packet stream. Three kinds of pattern come out of a single 32-bit shift register:

- a pseudo-random sequence whose feedback polynomial x^z + x^y + 1 and starting seed are set at run time;
- a fixed quasi-random sequence built on x^20 + x^17 + 1, in which long runs of zeros are cut short;
- a user word of run-time length that repeats end to end.

The consumer raises `advance` once for each payload bit it takes. The same bits, after optional inversion, are also gathered most-significant-bit first into bytes for byte-wide payload paths.

Software sets up the mode fields, the seed or word and the stream number, then pulses `load` while `gen_en` is high. The block takes a copy of the settings at that edge and starts producing the pattern. Later changes to the set-up inputs have no effect until the next load. The one exception is the inversion control, which acts at once.

Top module: `bert_pattern_gen`

## Requirements
- R1: After reset `bit_valid`, `bit_out` and `byte_valid` are 0, and `byte_out` and `stream_id` read 0.
- R2: A cycle with `load`=1 and `gen_en`=1 copies the set-up inputs, loads the register and sets `bit_valid` from the next cycle on. A `load` while `gen_en`=0 is ignored. Set-up inputs other than `invert` that change while running have no effect until the next load.
- R3: Pseudo-random mode is selected by `qrss_sel`=0 and `pat_rep`=0. With n=`len_fld` the register span is z=n+1, and n=0 is taken as z=2. With t=`tap_fld`, the tap is y=t when 1<=t<=z-1, otherwise y=1. The span is loaded with the low z bits of `seed_val`. The pattern bit is register bit z-1. Each step shifts the span left by one and fills bit 0 with the XOR of bits z-1 and y-1.
- R4: In pseudo-random mode, a seed whose low z bits are all zero loads all ones into the span instead.
- R5: `qrss_sel`=1 selects quasi-random mode whatever `pat_rep` is. It uses z=20 and y=17 with the R3 stepping, starts from all ones, and ignores `len_fld`, `tap_fld` and `seed_val`.
- R6: In quasi-random mode, when the last 14 pattern bits since the load were all 0, the pattern bit is forced to 1. The underlying register steps as usual.
- R7: Repetitive mode is selected by `qrss_sel`=0 and `pat_rep`=1. The word length is L=`len_fld`+1 and the word is the low L bits of `seed_val`. The word is sent from bit L-1 down to bit 0 and then repeats. `tap_fld` is ignored.
- R8: `invert`=1 flips `bit_out`, and the flipped bits are the ones packed into bytes. The control acts without a load.
- R9: The register advances exactly once per cycle with `advance`=1 while running and `load`=0. Without `advance`, `bit_out` holds, apart from inversion changes.
- R10: Every 8th advance since the load, `byte_valid` pulses for one cycle on the next cycle. `byte_out` then holds those 8 output bits, the first one in bit 7. A load or a disable restarts the byte count.
- R11: `gen_en`=0 clears `bit_valid` from the next cycle on. `bit_out` is 0 whenever `bit_valid` is 0, and `advance` is ignored until a new load.
- R12: `stream_id` takes the value of `stream_sel` at each accepted load and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable |
| stream_sel | input | STREAM_W | Outgoing stream that is to carry the pattern |
| pat_rep | input | 1 | 0 selects pseudo-random, 1 selects the repetitive word |
| qrss_sel | input | 1 | 1 selects quasi-random; overrides `pat_rep` |
| len_fld | input | 5 | z-1 for pseudo-random, L-1 for repetitive |
| tap_fld | input | 5 | Second polynomial exponent y |
| seed_val | input | 32 | Seed or repetitive word |
| load | input | 1 | Copy the set-up and start the pattern |
| invert | input | 1 | Invert every output bit |
| advance | input | 1 | Consume one pattern bit |
| bit_out | output | 1 | Current pattern bit |
| bit_valid | output | 1 | Generator running |
| byte_out | output | 8 | Last packed byte |
| byte_valid | output | 1 | One-cycle pulse when a new byte is ready |
| stream_id | output | STREAM_W | Stream number copied at load |

## Verification
On every cycle the assertions check these rules:
- a load starts the generator and a disable stops it;
- an idle generator drives zeros and an unadvanced bit holds still;
- byte pulses are isolated;
- the stream number changes only at a load;
- in quasi-random mode, an independent count of zeros keeps runs to at most 14 and forces a one after 14 zeros.

The actual bit values are shown only by the bench's scenarios, which compare them against its own model. Those scenarios cover each polynomial span and tap choice, the zero-seed substitution, the repeating words of several lengths, byte packing order and restart, and a quasi-random run long enough to reach the zero limit.

// File: rtl/bert_gen_pkg.sv
// Shared constants, the pattern-kind type and a span-mask helper for the
// BERT pattern generator. Assumes the register is at least 20 bits wide
// so that the fixed quasi-random polynomial fits.
package bert_gen_pkg;

    localparam int REG_W    = 32;
    localparam int IDX_W    = $clog2(REG_W);
    localparam int QRSS_MSB = 19;   // x^20 -> register bit 19
    localparam int QRSS_TAP = 16;   // x^17 -> register bit 16
    localparam int ZRUN_MAX = 14;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        PAT_PRBS = 2'd0,
        PAT_REP  = 2'd1,
        PAT_QRSS = 2'd2
    } pat_kind_e;

    // Ones in bits 0..top, zeros above.
    function automatic logic [REG_W-1:0] span_mask(input logic [IDX_W-1:0] top);
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i <= int'(top));
        end
        return m;
    endfunction

endpackage

// File: rtl/bert_cfg_decode.sv
// Turns the raw set-up fields into a pattern kind, the index of the span's
// top bit and the feedback tap index. Purely combinational. Assumes the
// caller registers the result at load time.
module bert_cfg_decode
    import bert_gen_pkg::*;
(
    input  logic             pat_rep,
    input  logic             qrss_sel,
    input  logic [IDX_W-1:0] len_fld,
    input  logic [IDX_W-1:0] tap_fld,
    output pat_kind_e        kind,
    output logic [IDX_W-1:0] msb_idx,
    output logic [IDX_W-1:0] tap_idx
);

    // Pick the mode and clamp out-of-range exponents.
    always_comb begin
        if (qrss_sel) begin
            kind    = PAT_QRSS;
            msb_idx = IDX_W'(QRSS_MSB);
            tap_idx = IDX_W'(QRSS_TAP);
        end else if (pat_rep) begin
            kind    = PAT_REP;
            msb_idx = len_fld;
            tap_idx = '0;
        end else begin
            kind    = PAT_PRBS;
            msb_idx = (len_fld == '0) ? IDX_W'(1) : len_fld;
            if (tap_fld != '0 && tap_fld <= msb_idx) begin
                tap_idx = tap_fld - 1'b1;
            end else begin
                tap_idx = '0;
            end
        end
    end

endmodule

// File: rtl/bert_shift_engine.sv
// The single shift register behind all three pattern kinds. It loads from the
// seed (or from all ones), then steps as a linear feedback register or as a
// rotator. The raw pattern bit is the top bit of the active span.
// Assumes msb/tap indices were checked by the decoder.
module bert_shift_engine
    import bert_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_go,
    input  pat_kind_e        ld_kind,
    input  logic [IDX_W-1:0] ld_msb,
    input  logic [REG_W-1:0] ld_seed,
    input  logic             step,
    input  pat_kind_e        run_kind,
    input  logic [IDX_W-1:0] run_msb,
    input  logic [IDX_W-1:0] run_tap,
    output logic             raw_bit
);

    logic [REG_W-1:0] state;
    logic [REG_W-1:0] ld_mask;
    logic [REG_W-1:0] load_val;
    logic [REG_W-1:0] next_val;
    logic             fill_bit;

    // Value placed in the register on a load, with zero-seed protection.
    always_comb begin
        ld_mask = span_mask(ld_msb);
        case (ld_kind)
            PAT_QRSS: load_val = ld_mask;
            PAT_REP:  load_val = ld_seed & ld_mask;
            default:  load_val = ((ld_seed & ld_mask) == '0) ? ld_mask : (ld_seed & ld_mask);
        endcase
    end

    // Next state for one step: feedback XOR or plain rotation.
    always_comb begin
        if (run_kind == PAT_REP) begin
            fill_bit = state[run_msb];
        end else begin
            fill_bit = state[run_msb] ^ state[run_tap];
        end
        next_val = {state[REG_W-2:0], fill_bit} & span_mask(run_msb);
    end

    // Register update: load wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (load_go) begin
            state <= load_val;
        end else if (step) begin
            state <= next_val;
        end
    end

    assign raw_bit = state[run_msb];

endmodule

// File: rtl/bert_zero_limiter.sv
// Counts consecutive zero pattern bits and forces a one once the count
// reaches the limit. It is active only while limit_en is high (quasi-random
// mode). Assumes clear is raised on every load and every disable.
module bert_zero_limiter #(
    parameter int RUN_MAX = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic limit_en,
    input  logic raw_bit,
    output logic pat_bit
);

    localparam int CNT_W = $clog2(RUN_MAX + 1);

    logic [CNT_W-1:0] zcnt;
    logic             force_one;

    assign force_one = limit_en && (zcnt == CNT_W'(RUN_MAX));
    assign pat_bit   = raw_bit | force_one;

    // Track the length of the current run of emitted zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcnt <= '0;
        end else if (clear) begin
            zcnt <= '0;
        end else if (step && limit_en) begin
            zcnt <= pat_bit ? '0 : zcnt + 1'b1;
        end
    end

endmodule

// File: rtl/bert_byte_packer.sv
// Gathers output bits most-significant-bit first and emits a byte with a
// one-cycle valid pulse after every BYTE_LEN steps.
// Assumes BYTE_LEN >= 3 and that clear restarts the count.
module bert_byte_packer #(
    parameter int BYTE_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    input  logic                bit_in,
    output logic [BYTE_LEN-1:0] byte_out,
    output logic                byte_valid
);

    localparam int CNT_W = $clog2(BYTE_LEN);

    logic [CNT_W-1:0]    cnt;
    logic [BYTE_LEN-2:0] acc;

    // Shift bits in and publish a full byte on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            acc        <= '0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else if (clear) begin
            cnt        <= '0;
            byte_valid <= 1'b0;
        end else if (step) begin
            acc <= {acc[BYTE_LEN-3:0], bit_in};
            if (cnt == CNT_W'(BYTE_LEN - 1)) begin
                byte_out   <= {acc, bit_in};
                byte_valid <= 1'b1;
                cnt        <= '0;
            end else begin
                byte_valid <= 1'b0;
                cnt        <= cnt + 1'b1;
            end
        end else begin
            byte_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/bert_pattern_gen.sv
// Top level of the BERT pattern generator. It copies the set-up at load,
// runs the shared shift engine, applies quasi-random zero limiting and live
// inversion, and packs the output into bytes.
// Assumes one advance strobe per consumed payload bit.
module bert_pattern_gen
    import bert_gen_pkg::*;
#(
    parameter int STREAM_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_en,
    input  logic [STREAM_W-1:0] stream_sel,
    input  logic                pat_rep,
    input  logic                qrss_sel,
    input  logic [IDX_W-1:0]    len_fld,
    input  logic [IDX_W-1:0]    tap_fld,
    input  logic [REG_W-1:0]    seed_val,
    input  logic                load,
    input  logic                invert,
    input  logic                advance,
    output logic                bit_out,
    output logic                bit_valid,
    output logic [BYTE_W-1:0]   byte_out,
    output logic                byte_valid,
    output logic [STREAM_W-1:0] stream_id
);

    logic                load_go;
    logic                step;
    logic                restart;
    logic                running;
    pat_kind_e           dec_kind;
    pat_kind_e           kind_q;
    logic [IDX_W-1:0]    dec_msb;
    logic [IDX_W-1:0]    dec_tap;
    logic [IDX_W-1:0]    msb_q;
    logic [IDX_W-1:0]    tap_q;
    logic [STREAM_W-1:0] stream_q;
    logic                raw_bit;
    logic                pat_bit;

    assign load_go = gen_en & load;
    assign step    = gen_en & running & advance & ~load;
    assign restart = load_go | ~gen_en;

    bert_cfg_decode u_dec (
        .pat_rep  (pat_rep),
        .qrss_sel (qrss_sel),
        .len_fld  (len_fld),
        .tap_fld  (tap_fld),
        .kind     (dec_kind),
        .msb_idx  (dec_msb),
        .tap_idx  (dec_tap)
    );

    // Hold the decoded set-up and the stream number from the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= PAT_PRBS;
            msb_q    <= IDX_W'(1);
            tap_q    <= '0;
            stream_q <= '0;
        end else if (load_go) begin
            kind_q   <= dec_kind;
            msb_q    <= dec_msb;
            tap_q    <= dec_tap;
            stream_q <= stream_sel;
        end
    end

    // Running flag: set by an accepted load, cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (!gen_en) begin
            running <= 1'b0;
        end else if (load) begin
            running <= 1'b1;
        end
    end

    bert_shift_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .ld_kind  (dec_kind),
        .ld_msb   (dec_msb),
        .ld_seed  (seed_val),
        .step     (step),
        .run_kind (kind_q),
        .run_msb  (msb_q),
        .run_tap  (tap_q),
        .raw_bit  (raw_bit)
    );

    bert_zero_limiter #(
        .RUN_MAX (ZRUN_MAX)
    ) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .step     (step),
        .limit_en (kind_q == PAT_QRSS),
        .raw_bit  (raw_bit),
        .pat_bit  (pat_bit)
    );

    assign bit_out   = running & (pat_bit ^ invert);
    assign bit_valid = running;
    assign stream_id = stream_q;

    bert_byte_packer #(
        .BYTE_LEN (BYTE_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .step       (step),
        .bit_in     (bit_out),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

endmodule

// File: rtl/bert_gen_checker.sv
// Protocol and pattern-rule assertions for bert_pattern_gen, attached by bind.
// Keeps its own count of zero pattern bits, derived from the ports only.
module bert_gen_checker
    import bert_gen_pkg::*;
#(
    parameter int STREAM_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                gen_en,
    input logic                load,
    input logic                advance,
    input logic                invert,
    input logic                bit_out,
    input logic                bit_valid,
    input logic                byte_valid,
    input logic [STREAM_W-1:0] stream_id,
    input pat_kind_e           kind
);

    logic [4:0] zrun;

    // Independent run-of-zeros count on the un-inverted output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (gen_en && load) begin
            zrun <= '0;
        end else if (gen_en && bit_valid && advance) begin
            if (bit_out ^ invert) begin
                zrun <= '0;
            end else if (zrun != 5'd31) begin
                zrun <= zrun + 1'b1;
            end
        end
    end

    AST_ZRUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAT_QRSS && bit_valid) |-> (zrun <= 5'(ZRUN_MAX))); // R6

    AST_ZRUN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAT_QRSS && bit_valid && zrun == 5'(ZRUN_MAX)) |-> (bit_out ^ invert)); // R6

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && load) |=> bit_valid); // R2

    AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !bit_valid); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !bit_out); // R11

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && bit_valid && !advance && !load)
        |=> (!bit_valid || (invert != $past(invert)) || $stable(bit_out))); // R9

    AST_BYTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R10

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_en && load) |=> $stable(stream_id)); // R12

endmodule

bind bert_pattern_gen bert_gen_checker #(
    .STREAM_W (STREAM_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .load       (load),
    .advance    (advance),
    .invert     (invert),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid),
    .byte_valid (byte_valid),
    .stream_id  (stream_id),
    .kind       (kind_q)
);

// File: tb/tb_bert_pattern_gen.sv
// Self-checking bench: a behavioural model steps alongside the generator
// and every output is compared on every clock.
module tb_bert_pattern_gen;

    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gen_en = 1'b0;
    logic [SW-1:0] stream_sel = '0;
    logic          pat_rep = 1'b0;
    logic          qrss_sel = 1'b0;
    logic [4:0]    len_fld = '0;
    logic [4:0]    tap_fld = '0;
    logic [31:0]   seed_val = '0;
    logic          load = 1'b0;
    logic          invert = 1'b0;
    logic          advance = 1'b0;
    logic          bit_out;
    logic          bit_valid;
    logic [7:0]    byte_out;
    logic          byte_valid;
    logic [SW-1:0] stream_id;

    int  nvec = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    // model state
    bit          m_run = 0;
    int          m_kind = 0;   // 0 pseudo-random, 1 repetitive, 2 quasi-random
    int          m_msb = 1;
    int          m_tap = 0;
    logic [31:0] m_state = '0;
    bit          m_hist[$];
    bit          m_bits[$];
    logic [7:0]  m_byte = '0;
    bit          m_bv = 0;
    logic [SW-1:0] m_sid = '0;

    always #5 clk = ~clk;

    bert_pattern_gen #(.STREAM_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .stream_sel(stream_sel),
        .pat_rep(pat_rep), .qrss_sel(qrss_sel), .len_fld(len_fld),
        .tap_fld(tap_fld), .seed_val(seed_val), .load(load), .invert(invert),
        .advance(advance), .bit_out(bit_out), .bit_valid(bit_valid),
        .byte_out(byte_out), .byte_valid(byte_valid), .stream_id(stream_id)
    );

    function automatic logic [31:0] mmask(input int top);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (i <= top);
        return m;
    endfunction

    function automatic bit m_pat();
        bit all0;
        if (m_kind == 2 && m_hist.size() == 14) begin
            all0 = 1;
            foreach (m_hist[i]) if (m_hist[i]) all0 = 0;
            if (all0) return 1'b1;
        end
        return m_state[m_msb];
    endfunction

    task automatic model_step();
        bit p, ob, fill;
        if (!gen_en) begin
            m_run = 0; m_bits.delete(); m_bv = 0;
        end else if (load) begin
            if (qrss_sel) begin m_kind = 2; m_msb = 19; m_tap = 16; end
            else if (pat_rep) begin m_kind = 1; m_msb = int'(len_fld); m_tap = 0; end
            else begin
                m_kind = 0;
                m_msb = (len_fld == 0) ? 1 : int'(len_fld);
                m_tap = (int'(tap_fld) >= 1 && int'(tap_fld) <= m_msb) ? int'(tap_fld) - 1 : 0;
            end
            if (m_kind == 2) m_state = mmask(m_msb);
            else begin
                m_state = seed_val & mmask(m_msb);
                if (m_kind == 0 && m_state == 0) m_state = mmask(m_msb);
            end
            m_run = 1; m_hist.delete(); m_bits.delete(); m_bv = 0; m_sid = stream_sel;
        end else if (m_run && advance) begin
            p  = m_pat();
            ob = p ^ invert;
            m_hist.push_back(p);
            if (m_hist.size() > 14) void'(m_hist.pop_front());
            m_bits.push_back(ob);
            if (m_bits.size() == 8) begin
                m_byte = '0;
                for (int i = 0; i < 8; i++) m_byte = {m_byte[6:0], m_bits[i]};
                m_bits.delete();
                m_bv = 1;
            end else m_bv = 0;
            fill = (m_kind == 1) ? m_state[m_msb] : (m_state[m_msb] ^ m_state[m_tap]);
            m_state = ((m_state << 1) | {31'd0, fill}) & mmask(m_msb);
        end else begin
            m_bv = 0;
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        bit eb;
        eb = m_run ? (m_pat() ^ invert) : 1'b0;
        chk(tag, "bit_valid", 32'(bit_valid), 32'(m_run));
        chk(tag, "bit_out", 32'(bit_out), 32'(eb));
        chk(tag, "byte_valid", 32'(byte_valid), 32'(m_bv));
        chk(tag, "byte_out", 32'(byte_out), 32'(m_byte));
        chk(tag, "stream_id", 32'(stream_id), 32'(m_sid));
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_load(input string tag, input bit rep, input bit q, input logic [4:0] ln,
                           input logic [4:0] tp, input logic [31:0] sd, input logic [SW-1:0] sid);
        pat_rep = rep; qrss_sel = q; len_fld = ln; tap_fld = tp; seed_val = sd; stream_sel = sid;
        load = 1'b1;
        tick(tag);
        load = 1'b0;
    endtask

    task automatic run_adv(input string tag, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            advance = !(gaps && (i % 3 == 2));
            tick(tag);
        end
        advance = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "bit_valid", 32'(bit_valid), 0);
        chk("R1", "bit_out", 32'(bit_out), 0);
        chk("R1", "byte_valid", 32'(byte_valid), 0);
        chk("R1", "byte_out", 32'(byte_out), 0);
        chk("R1", "stream_id", 32'(stream_id), 0);
        tick("R1");

        // R2: load while disabled is ignored
        do_load("R2", 0, 0, 5'd6, 5'd6, 32'h5A, 6'd3);
        run_adv("R2", 4, 0);

        gen_en = 1'b1;
        // R3: x^7 + x^6 + 1 with gaps (R9 holds on idle cycles)
        do_load("R12", 0, 0, 5'd6, 5'd6, 32'h5A, 6'd5);
        run_adv("R3", 200, 0);
        run_adv("R9", 60, 1);
        // R8: live inversion
        invert = 1'b1;
        run_adv("R8", 50, 1);
        invert = 1'b0;
        // R2: set-up changes without a load are ignored
        pat_rep = 1'b1; len_fld = 5'd3; tap_fld = 5'd1; seed_val = 32'hFFFF; stream_sel = 6'd9;
        run_adv("R2", 40, 0);
        // R4: zero seed
        do_load("R4", 0, 0, 5'd8, 5'd4, 32'hFFFF_FE00, 6'd7);
        run_adv("R4", 60, 0);
        // R3: full 32-bit span, and the clamped minimum span
        do_load("R3", 0, 0, 5'd31, 5'd22, 32'hDEAD_BEEF, 6'd1);
        run_adv("R3", 300, 1);
        do_load("R3", 0, 0, 5'd0, 5'd0, 32'h2, 6'd2);
        run_adv("R3", 20, 0);
        // R5/R6: quasi-random, set-up fields ignored
        do_load("R5", 1, 1, 5'd3, 5'd2, 32'h1234, 6'd4);
        run_adv("R5", 200, 0);
        do_load("R5", 0, 1, 5'd9, 5'd30, 32'h0, 6'd4);
        run_adv("R6", 60000, 0);
        // R7/R10: repetitive words
        do_load("R7", 1, 0, 5'd7, 5'd3, 32'hFFFF_FFA5, 6'd8);
        run_adv("R10", 64, 0);
        do_load("R7", 1, 0, 5'd4, 5'd9, 32'h16, 6'd8);
        run_adv("R7", 40, 1);
        invert = 1'b1;
        run_adv("R8", 16, 0);
        invert = 1'b0;
        do_load("R7", 1, 0, 5'd31, 5'd0, 32'h1234_5678, 6'd10);
        run_adv("R10", 64, 0);
        // R10: reload mid-byte restarts the count
        run_adv("R10", 3, 0);
        do_load("R10", 1, 0, 5'd7, 5'd0, 32'h3C, 6'd11);
        run_adv("R10", 24, 0);
        // R11: disable stops and ignores advance
        run_adv("R11", 5, 0);
        gen_en = 1'b0;
        run_adv("R11", 10, 0);
        gen_en = 1'b1;
        run_adv("R11", 10, 0);
        do_load("R11", 0, 0, 5'd14, 5'd13, 32'h7FFF, 6'd12);
        run_adv("R11", 40, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule